// File: doc/BRIEF.md
# Magnitude-Duty Gain Controller for a Two-Bit Sampler

This block closes the gain loop around an IF channel whose output is digitised by a two-bit sampler (a sign bit and a magnitude bit). Under thermal noise the share of samples with the magnitude bit set tracks signal power. The block tallies that share over a fixed window of valid samples. At the end of each window it compares the tally with a programmable target and a dead band. It then moves a 5-bit amplifier gain code (code k stands for 2k dB, 0 to 62 dB) one step up or down, so that the magnitude bit settles near one third duty. With a window of n samples the target is normally about round(n/3).

The sign bit plays no part in the decision, so only the magnitude bit enters the block. When the loop is disabled, the gain follows a manual code and the window logic is held clear. When the loop is re-enabled, it carries on from that manual code. A one-cycle strobe marks each decision, and the tally of the last finished window stays on an output for observation.

Top module: `agc_mag_duty_ctrl`

## Requirements
- R1: The window length is 64 << win_sel valid samples for win_sel 0 to 6, and any larger win_sel gives 4096. win_strobe is high in the cycle after the clock edge that takes the window's last valid sample.
- R2: Along with each strobe, win_count holds the number of valid samples in that window whose magnitude bit was 1. A cycle with smp_vld low does not count, whatever mag_bit is, and does not advance the window.
- R3: If the window tally is greater than thr + hyst, the gain code drops by one.
- R4: If tally + hyst is less than thr, the gain code rises by one. Otherwise the code is held. Any change lands one cycle after the strobe, and the code never changes at any other time while enabled.
- R5: The code stops at 0 and at 31. A decrease requested at 0 sets at_min, and an increase requested at 31 sets at_max. Each flag stays set while the code remains at that limit and clears when the code moves away.
- R6: win_strobe lasts exactly one cycle. The tally and the sample position restart together after each decision, so the next window starts empty.
- R7: While en is low, the gain code takes man_gain at every clock edge, the window logic is cleared, no strobe occurs and both flags are low. After en rises, the loop starts from that code with a fresh window.
- R8: While rst is high, the gain code is 16, win_strobe is 0, win_count is 0 and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Closes the loop when high; manual gain when low |
| smp_vld | input | 1 | Marks a cycle that carries a sample |
| mag_bit | input | 1 | Magnitude bit of the two-bit sample |
| win_sel | input | 3 | Window length select, 64 << win_sel |
| thr | input | 13 | Target tally per window |
| hyst | input | 13 | Half-width of the dead band around the target |
| man_gain | input | 5 | Gain code used while disabled |
| gain_code | output | 5 | Amplifier gain code, 2 dB per step |
| win_strobe | output | 1 | One-cycle decision pulse |
| win_count | output | 13 | Tally of the last finished window |
| at_min | output | 1 | Lower gain limit reached |
| at_max | output | 1 | Upper gain limit reached |

## Verification
The strobe and the tally appear in the cycle after the edge that takes the last valid sample of a window. The new gain code and the limit flags appear one cycle later. A manual code appears one edge after en is low. The bench drives inputs on falling edges. Each window ends with one idle cycle, and the bench then reads the strobe and tally on that falling edge and reads the gain and flags on the next falling edge, so every reading falls on the exact cycle in which the register that drives it has updated.

// File: rtl/agc_pkg.sv
package agc_pkg;

    localparam int GAIN_W    = 5;
    localparam int GAIN_MAX  = (1 << GAIN_W) - 1;
    localparam int SEL_W     = 3;
    localparam int SEL_MAX   = 6;
    localparam int BASE_LOG2 = 6;
    localparam int CNT_W     = BASE_LOG2 + SEL_MAX + 1;

    localparam logic [GAIN_W-1:0] GAIN_RST = GAIN_W'(16);

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;

    typedef struct packed {
        logic             done;
        logic [CNT_W-1:0] ones;
    } window_t;

    function automatic logic [CNT_W-1:0] win_len(input logic [SEL_W-1:0] sel);
        logic [SEL_W-1:0] s;
        s = (sel > SEL_W'(SEL_MAX)) ? SEL_W'(SEL_MAX) : sel;
        return CNT_W'(1) << (BASE_LOG2 + int'(s));
    endfunction

endpackage

// File: rtl/agc_window_counter.sv
module agc_window_counter
    import agc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             smp_vld,
    input  logic             mag_bit,
    input  logic [SEL_W-1:0] win_sel,
    output window_t          win_o
);

    logic [CNT_W-1:0] idx_q;
    logic [CNT_W-1:0] ones_q;
    logic [CNT_W-1:0] len;
    logic [CNT_W-1:0] ones_n;
    logic             last;

    always_comb begin
        len    = win_len(win_sel);
        ones_n = ones_q + CNT_W'(mag_bit);
        last   = (idx_q >= len - CNT_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q  <= '0;
            ones_q <= '0;
            win_o  <= '0;
        end else if (!run) begin
            idx_q      <= '0;
            ones_q     <= '0;
            win_o.done <= 1'b0;
        end else begin
            win_o.done <= 1'b0;
            if (smp_vld) begin
                if (last) begin
                    idx_q      <= '0;
                    ones_q     <= '0;
                    win_o.done <= 1'b1;
                    win_o.ones <= ones_n;
                end else begin
                    idx_q  <= idx_q + CNT_W'(1);
                    ones_q <= ones_n;
                end
            end
        end
    end

endmodule

// File: rtl/agc_step_decide.sv
module agc_step_decide
    import agc_pkg::*;
(
    input  window_t          win_i,
    input  logic [CNT_W-1:0] thr,
    input  logic [CNT_W-1:0] hyst,
    output step_e            step
);

    logic [CNT_W:0] upper;
    logic [CNT_W:0] lifted;

    always_comb begin
        upper  = {1'b0, thr} + {1'b0, hyst};
        lifted = {1'b0, win_i.ones} + {1'b0, hyst};
        step   = STEP_HOLD;
        if (win_i.done) begin
            if ({1'b0, win_i.ones} > upper) begin
                step = STEP_DOWN;
            end else if (lifted < {1'b0, thr}) begin
                step = STEP_UP;
            end
        end
    end

endmodule

// File: rtl/agc_gain_reg.sv
module agc_gain_reg
    import agc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [GAIN_W-1:0] man_gain,
    input  step_e             step,
    output logic [GAIN_W-1:0] gain_q,
    output logic              at_min_q,
    output logic              at_max_q
);

    localparam logic [GAIN_W-1:0] TOP = GAIN_W'(GAIN_MAX);

    logic [GAIN_W-1:0] gain_n;
    logic              hit_min;
    logic              hit_max;

    always_comb begin
        gain_n  = gain_q;
        hit_min = 1'b0;
        hit_max = 1'b0;
        unique case (step)
            STEP_DOWN: begin
                if (gain_q == '0) hit_min = 1'b1;
                else              gain_n  = gain_q - GAIN_W'(1);
            end
            STEP_UP: begin
                if (gain_q == TOP) hit_max = 1'b1;
                else               gain_n  = gain_q + GAIN_W'(1);
            end
            default: gain_n = gain_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gain_q   <= GAIN_RST;
            at_min_q <= 1'b0;
            at_max_q <= 1'b0;
        end else if (!run) begin
            gain_q   <= man_gain;
            at_min_q <= 1'b0;
            at_max_q <= 1'b0;
        end else begin
            gain_q   <= gain_n;
            at_min_q <= hit_min | (at_min_q & (gain_n == '0));
            at_max_q <= hit_max | (at_max_q & (gain_n == TOP));
        end
    end

endmodule

// File: rtl/agc_mag_duty_ctrl.sv
module agc_mag_duty_ctrl
    import agc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              smp_vld,
    input  logic              mag_bit,
    input  logic [SEL_W-1:0]  win_sel,
    input  logic [CNT_W-1:0]  thr,
    input  logic [CNT_W-1:0]  hyst,
    input  logic [GAIN_W-1:0] man_gain,
    output logic [GAIN_W-1:0] gain_code,
    output logic              win_strobe,
    output logic [CNT_W-1:0]  win_count,
    output logic              at_min,
    output logic              at_max
);

    window_t win;
    step_e   step;

    agc_window_counter u_win (
        .clk     (clk),
        .rst     (rst),
        .run     (en),
        .smp_vld (smp_vld),
        .mag_bit (mag_bit),
        .win_sel (win_sel),
        .win_o   (win)
    );

    agc_step_decide u_dec (
        .win_i (win),
        .thr   (thr),
        .hyst  (hyst),
        .step  (step)
    );

    agc_gain_reg u_gain (
        .clk      (clk),
        .rst      (rst),
        .run      (en),
        .man_gain (man_gain),
        .step     (step),
        .gain_q   (gain_code),
        .at_min_q (at_min),
        .at_max_q (at_max)
    );

    assign win_strobe = win.done;
    assign win_count  = win.ones;

endmodule

// File: rtl/agc_mag_duty_ctrl_chk.sv
module agc_mag_duty_ctrl_chk
    import agc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic [GAIN_W-1:0] man_gain,
    input logic [GAIN_W-1:0] gain_code,
    input logic              win_strobe,
    input logic [CNT_W-1:0]  win_count,
    input logic              at_min,
    input logic              at_max
);

    a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
        win_strobe |-> (win_count <= CNT_W'(1 << (BASE_LOG2 + SEL_MAX))));

    a_r3_single_step: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en)) |-> (gain_code == $past(gain_code) ||
                               gain_code == $past(gain_code) + 1 ||
                               gain_code + 1 == $past(gain_code)));

    a_r4_only_after_strobe: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && !$past(win_strobe)) |-> $stable(gain_code));

    a_r5_min_flag: assert property (@(posedge clk) disable iff (rst)
        at_min |-> (gain_code == '0));

    a_r5_max_flag: assert property (@(posedge clk) disable iff (rst)
        at_max |-> (gain_code == GAIN_W'(GAIN_MAX)));

    a_r6_strobe_once: assert property (@(posedge clk) disable iff (rst)
        win_strobe |=> !win_strobe);

    a_r7_manual: assert property (@(posedge clk) disable iff (rst)
        !en |=> (gain_code == $past(man_gain) && !win_strobe));

endmodule

bind agc_mag_duty_ctrl agc_mag_duty_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .man_gain   (man_gain),
    .gain_code  (gain_code),
    .win_strobe (win_strobe),
    .win_count  (win_count),
    .at_min     (at_min),
    .at_max     (at_max)
);

// File: tb/agc_mag_duty_ctrl_bench.sv
`timescale 1ns/1ps
module agc_mag_duty_ctrl_bench;
    import agc_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              en = 1'b0;
    logic              smp_vld = 1'b0;
    logic              mag_bit = 1'b0;
    logic [SEL_W-1:0]  win_sel = '0;
    logic [CNT_W-1:0]  thr = CNT_W'(21);
    logic [CNT_W-1:0]  hyst = CNT_W'(2);
    logic [GAIN_W-1:0] man_gain = GAIN_W'(9);
    logic [GAIN_W-1:0] gain_code;
    logic              win_strobe;
    logic [CNT_W-1:0]  win_count;
    logic              at_min;
    logic              at_max;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    agc_mag_duty_ctrl u_agc_mag_duty_ctrl (
        .clk(clk), .rst(rst), .en(en), .smp_vld(smp_vld), .mag_bit(mag_bit),
        .win_sel(win_sel), .thr(thr), .hyst(hyst), .man_gain(man_gain),
        .gain_code(gain_code), .win_strobe(win_strobe), .win_count(win_count),
        .at_min(at_min), .at_max(at_max)
    );

    // ones per 64-sample window (thr 21, hyst 2) and expected gain move from 16
    localparam int NV = 8;
    localparam int VK [NV] = '{30, 24, 23, 21, 19, 18, 0, 64};
    localparam int VD [NV] = '{-1, -1,  0,  0,  0,  1, 1, -1};

    task automatic chk(string req, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic feed(int n, int k, bit gaps);
        for (int i = 0; i < n; i++) begin
            if (gaps) begin
                @(negedge clk); smp_vld = 1'b0; mag_bit = 1'b1;
            end
            @(negedge clk); smp_vld = 1'b1; mag_bit = (i < k);
        end
        @(negedge clk); smp_vld = 1'b0; mag_bit = 1'b0;
    endtask

    task automatic start(int man);
        @(negedge clk); en = 1'b0; man_gain = GAIN_W'(man);
        @(negedge clk); en = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R8: reset state
        repeat (2) @(negedge clk);
        chk("R8 gain", int'(gain_code), 16);
        chk("R8 strobe", int'(win_strobe), 0);
        chk("R8 count", int'(win_count), 0);
        chk("R8 flags", int'({at_min, at_max}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R7 manual after reset", int'(gain_code), 9);

        // R3/R4 vector table
        for (int v = 0; v < NV; v++) begin
            start(16);
            feed(64, VK[v], 1'b0);
            chk("R1 strobe", int'(win_strobe), 1);
            chk("R2 count", int'(win_count), VK[v]);
            @(negedge clk);
            chk(VD[v] < 0 ? "R3 lower" : "R4 raise/hold", int'(gain_code), 16 + VD[v]);
            chk("R6 strobe width", int'(win_strobe), 0);
        end

        // R2: invalid cycles with mag high are ignored
        start(16);
        feed(64, 10, 1'b1);
        chk("R2 gaps strobe", int'(win_strobe), 1);
        chk("R2 gaps count", int'(win_count), 10);
        @(negedge clk);
        chk("R4 raise after gaps", int'(gain_code), 17);

        // R6: back-to-back windows restart empty
        feed(64, 21, 1'b0);
        chk("R6 second count", int'(win_count), 21);
        @(negedge clk);
        chk("R6 hold", int'(gain_code), 17);

        // R1: 128-sample window
        win_sel = SEL_W'(1);
        thr = CNT_W'(43); hyst = CNT_W'(3);
        start(16);
        feed(127, 127, 1'b0);
        chk("R1 no early strobe", int'(win_strobe), 0);
        feed(1, 1, 1'b0);
        chk("R1 strobe 128", int'(win_strobe), 1);
        chk("R1 count 128", int'(win_count), 128);
        @(negedge clk);
        chk("R3 lower 128", int'(gain_code), 15);
        win_sel = '0; thr = CNT_W'(21); hyst = CNT_W'(2);

        // R5: upper limit
        start(31);
        feed(64, 0, 1'b0);
        @(negedge clk);
        chk("R5 stay 31", int'(gain_code), 31);
        chk("R5 at_max set", int'(at_max), 1);
        feed(64, 64, 1'b0);
        @(negedge clk);
        chk("R5 leave 31", int'(gain_code), 30);
        chk("R5 at_max clear", int'(at_max), 0);

        // R5: lower limit
        start(0);
        feed(64, 64, 1'b0);
        @(negedge clk);
        chk("R5 stay 0", int'(gain_code), 0);
        chk("R5 at_min set", int'(at_min), 1);
        feed(64, 0, 1'b0);
        @(negedge clk);
        chk("R5 leave 0", int'(gain_code), 1);
        chk("R5 at_min clear", int'(at_min), 0);

        // R7: disable mid-window clears the window
        start(20);
        feed(40, 40, 1'b0);
        @(negedge clk); en = 1'b0; man_gain = GAIN_W'(5);
        @(negedge clk);
        chk("R7 manual code", int'(gain_code), 5);
        chk("R7 no strobe", int'(win_strobe), 0);
        en = 1'b1;
        feed(24, 24, 1'b0);
        chk("R7 window cleared", int'(win_strobe), 0);
        feed(40, 0, 1'b0);
        chk("R7 fresh strobe", int'(win_strobe), 1);
        chk("R7 fresh count", int'(win_count), 24);
        @(negedge clk);
        chk("R7 resume lower", int'(gain_code), 4);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule